// File: doc/BRIEF.md
# Two-Class Interrupt Priority Resolver

This block picks one winning interrupt line for one interrupt class, normal or fast. It looks at up to three banks of 32 lines. For each line it takes a pending bit, a mask bit, a route bit that assigns the line to one class, and a priority value. Only lines that belong to the requested class, are pending and are not masked take part. The winner is the line with the smallest priority number. When several lines share that number, the line with the highest global index wins.

A pulse on `start` asks for a resolution, and `fiq_mode` selects the class. A parameter chooses how the search is done. In combinational form the result is captured at the clock edge that samples `start`. In scan form one line is examined per cycle, and the result appears after the last line has been examined. In both forms `done` stays high from the result until the next `start`, and `valid` and `index` change only when a result is delivered. The pending, mask, route, priority and class inputs must be held steady from `start` until `done`.

Top module: `prio_resolver`

## Requirements
- R1: Among the candidate lines, the one with the numerically smallest priority value wins, and value 0 beats every other value.
- R2: When candidates tie on the smallest priority, the candidate with the highest global index wins, including when the tied lines sit in different banks.
- R3: A line is a candidate only when its pending bit is 1 and its mask bit is 0. Its route bit must also equal `fiq_mode`: route 1 marks a fast line and route 0 marks a normal line. Masked lines and lines of the other class never win, whatever their priority.
- R4: The reported index is 32 times the bank number plus the bit position within the bank. Line k of the flat input vectors is bit k mod 32 of bank k/32.
- R5: Parameter NBANKS (1 to 3) sets the number of lines to 32×NBANKS. Lines above that range do not exist, and `index` is always below 32×NBANKS when `valid` is 1.
- R6: When no line qualifies, the delivered result has `valid` 0 and `index` keeps the value it had before.
- R7: In scan mode (SEQ_SCAN=1), `done` is 0 in the cycle after `start` and rises exactly 32×NBANKS cycles after the edge that sampled `start`. In combinational mode, `done` is 1 in the cycle after `start`. In both modes `done` then stays 1 until the next `start`.
- R8: Parameter PRIO_W sets the width of each priority field (5 or 6 bits). Every bit of that field counts in the comparison, so in a 6-bit build the value 31 beats 32 and 33.
- R9: A `start` that arrives while a scan is running abandons that scan. The full latency is counted again from the new `start`, and the result reflects the inputs held during the new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to resolve |
| fiq_mode | input | 1 | Class to resolve: 1 fast, 0 normal |
| pend | input | 32×NBANKS | Pending bit per line |
| mask | input | 32×NBANKS | Mask bit per line, 1 = blocked |
| route | input | 32×NBANKS | Class route per line, 1 = fast |
| prio | input | 32×NBANKS×PRIO_W | Priority field per line, line k at bits k×PRIO_W upward |
| done | output | 1 | Result available and stable |
| valid | output | 1 | A candidate was found |
| index | output | clog2(32×NBANKS) | Global index of the winner |

## Verification
Two events can fall in the same cycle: a new `start` and a scan that is still in progress. Either can update the result and the completion flag. The bench provokes this by starting a scan and changing the line inputs ten cycles into it. It then pulses `start` again while the first scan is still running. The check passes when `done` stays low for a full 32×NBANKS cycles after the second pulse and the delivered index belongs to the new inputs, not the abandoned ones. A second collision, tied priorities across bank boundaries next to a masked or wrongly routed line with a better priority, is judged against indices derived by hand.

// File: rtl/ipr_pkg.sv
// Package ipr_pkg
// Purpose : constants and types shared by the priority resolver modules.
// Assumes : a bank is always 32 lines wide and at most three banks exist.
package ipr_pkg;

    localparam int LINES_PER_BANK = 32;
    localparam int MAX_BANKS      = 3;

    // Class being resolved
    typedef enum logic {
        CLS_NORMAL = 1'b0,
        CLS_FAST   = 1'b1
    } irq_class_e;

    // State of the sequential scan engine
    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

endpackage

// File: rtl/ipr_qualify.sv
// Module ipr_qualify
// Purpose : marks which lines of one bank are candidates for the requested
//           class: pending, unmasked and routed to that class.
// Assumes : purely combinational; route bit 1 means fast class.
module ipr_qualify
    import ipr_pkg::*;
#(
    parameter int WIDTH = LINES_PER_BANK
) (
    input  logic [WIDTH-1:0] pend_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic [WIDTH-1:0] route_i,
    input  irq_class_e       cls_i,
    output logic [WIDTH-1:0] cand_o
);

    logic [WIDTH-1:0] class_match;

    // Select lines whose route agrees with the requested class
    always_comb begin
        if (cls_i == CLS_FAST) class_match = route_i;
        else                   class_match = ~route_i;
    end

    // A candidate must be pending and not blocked by its mask
    always_comb begin
        cand_o = pend_i & ~mask_i & class_match;
    end

endmodule

// File: rtl/ipr_comb_pick.sv
// Module ipr_comb_pick
// Purpose : finds the winning candidate over all lines in one cycle.
//           Smaller priority wins; equal priority goes to the higher index.
// Assumes : commit_o follows start_i directly; the caller registers results.
module ipr_comb_pick #(
    parameter int NLINES = 96,
    parameter int PRIO_W = 5,
    parameter int IDX_W  = $clog2(NLINES)
) (
    input  logic                     start_i,
    input  logic [NLINES-1:0]        cand_i,
    input  logic [NLINES*PRIO_W-1:0] prio_i,
    output logic                     commit_o,
    output logic                     found_o,
    output logic [IDX_W-1:0]         win_o
);

    logic [PRIO_W-1:0] best_p;

    // Walk lines from low to high index; "<=" lets a later tie take over
    always_comb begin
        found_o = 1'b0;
        best_p  = '0;
        win_o   = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (cand_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] <= best_p)) begin
                found_o = 1'b1;
                best_p  = prio_i[i*PRIO_W +: PRIO_W];
                win_o   = IDX_W'(i);
            end
        end
    end

    // Result is ready in the same cycle as the request
    always_comb begin
        commit_o = start_i;
    end

endmodule

// File: rtl/ipr_seq_scan.sv
// Module ipr_seq_scan
// Purpose : examines one line per cycle, keeping the best candidate so far,
//           and commits the result after the last line.
// Assumes : inputs stay steady during the scan; a new start restarts it.
module ipr_seq_scan
    import ipr_pkg::*;
#(
    parameter int NLINES = 96,
    parameter int PRIO_W = 5,
    parameter int IDX_W  = $clog2(NLINES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NLINES-1:0]        cand_i,
    input  logic [NLINES*PRIO_W-1:0] prio_i,
    output logic                     commit_o,
    output logic                     found_o,
    output logic [IDX_W-1:0]         win_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NLINES - 1);

    scan_state_e       state;
    logic [IDX_W-1:0]  cnt;
    logic              best_v;
    logic [PRIO_W-1:0] best_p;
    logic [IDX_W-1:0]  best_i;
    logic [PRIO_W-1:0] cur_p;
    logic              take;
    logic              at_last;

    // Look at the line currently under the cursor
    always_comb begin
        cur_p   = prio_i[int'(cnt)*PRIO_W +: PRIO_W];
        take    = cand_i[cnt] && (!best_v || cur_p <= best_p);
        at_last = (cnt == LAST);
    end

    // Final result including the line examined in this cycle
    always_comb begin
        commit_o = (state == SCAN_RUN) && at_last && !start_i;
        found_o  = best_v || take;
        win_o    = take ? cnt : best_i;
    end

    // Cursor, state and running best; start always restarts from line 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SCAN_IDLE;
            cnt    <= '0;
            best_v <= 1'b0;
            best_p <= '0;
            best_i <= '0;
        end else if (start_i) begin
            state  <= SCAN_RUN;
            cnt    <= '0;
            best_v <= 1'b0;
        end else if (state == SCAN_RUN) begin
            if (take) begin
                best_v <= 1'b1;
                best_p <= cur_p;
                best_i <= cnt;
            end
            if (at_last) state <= SCAN_IDLE;
            else         cnt   <= cnt + 1'b1;
        end
    end

    // R9: a start always puts the engine back into the running state
    assert_restart_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state == SCAN_RUN && cnt == '0));

    // R5: the cursor never leaves the configured line range
    assert_cursor_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SCAN_RUN) |-> (int'(cnt) < NLINES));

endmodule

// File: rtl/prio_resolver.sv
// Module prio_resolver
// Purpose : resolves the winning interrupt line of one class over
//           NBANKS banks of 32 lines, in one cycle or by a sequential scan.
// Assumes : line inputs and fiq_mode held steady from start until done;
//           synchronous active-low reset.
module prio_resolver
    import ipr_pkg::*;
#(
    parameter int NBANKS   = 3,
    parameter int PRIO_W   = 5,
    parameter int SEQ_SCAN = 0,
    localparam int NLINES  = NBANKS * LINES_PER_BANK,
    localparam int IDX_W   = $clog2(NLINES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     fiq_mode,
    input  logic [NLINES-1:0]        pend,
    input  logic [NLINES-1:0]        mask,
    input  logic [NLINES-1:0]        route,
    input  logic [NLINES*PRIO_W-1:0] prio,
    output logic                     done,
    output logic                     valid,
    output logic [IDX_W-1:0]         index
);

    irq_class_e        cls;
    logic [NLINES-1:0] cand;
    logic              commit;
    logic              found;
    logic [IDX_W-1:0]  win;

    // Map the class pin onto the shared enum
    always_comb begin
        cls = fiq_mode ? CLS_FAST : CLS_NORMAL;
    end

    // One qualifier per bank
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        ipr_qualify #(.WIDTH(LINES_PER_BANK)) u_qual (
            .pend_i  (pend [b*LINES_PER_BANK +: LINES_PER_BANK]),
            .mask_i  (mask [b*LINES_PER_BANK +: LINES_PER_BANK]),
            .route_i (route[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .cls_i   (cls),
            .cand_o  (cand [b*LINES_PER_BANK +: LINES_PER_BANK])
        );
    end

    // Choose the search engine
    if (SEQ_SCAN != 0) begin : g_seq
        ipr_seq_scan #(.NLINES(NLINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_eng (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start),
            .cand_i   (cand),
            .prio_i   (prio),
            .commit_o (commit),
            .found_o  (found),
            .win_o    (win)
        );
    end else begin : g_comb
        ipr_comb_pick #(.NLINES(NLINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_eng (
            .start_i  (start),
            .cand_i   (cand),
            .prio_i   (prio),
            .commit_o (commit),
            .found_o  (found),
            .win_o    (win)
        );
    end

    // Output register: done falls on start, rises on commit; index holds if none
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            valid <= 1'b0;
            index <= '0;
        end else begin
            if (commit)     done <= 1'b1;
            else if (start) done <= 1'b0;
            if (commit) begin
                valid <= found;
                if (found) index <= win;
            end
        end
    end

    // R5: a valid winner lies inside the configured line range
    assert_index_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(index) < NLINES));

    // R3: a delivered winner is pending, unmasked and of the requested class
    assert_winner_qualifies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && found) |-> (pend[win] && !mask[win] && (route[win] == fiq_mode)));

    // R6: a result without a candidate leaves the index untouched
    assert_index_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !found) |=> $stable(index));

    // R7: once done, it stays done until a new request
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    if (SEQ_SCAN != 0) begin : g_seq_chk
        // R7: a request in scan mode first clears done
        assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> !done);
    end else begin : g_comb_chk
        // R7: a request in combinational mode yields done one cycle later
        assert_done_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> done);
    end

endmodule

// File: tb/sim_prio_resolver.sv
// Bench for prio_resolver: u0 is a 3-bank, 5-bit combinational build;
// u1 is a 2-bank, 6-bit scanning build. Both share the line stimulus.
module sim_prio_resolver;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic fiq_mode = 1'b0;
    logic [95:0] pend = '0;
    logic [95:0] mask = '1;
    logic [95:0] route = '0;
    int unsigned pr [96];
    logic [96*5-1:0] p0;
    logic [64*6-1:0] p1;

    logic done0, valid0, done1, valid1;
    logic [6:0] index0;
    logic [5:0] index1;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // Pack per-line priorities for both builds
    always_comb begin
        for (int i = 0; i < 96; i++) p0[i*5 +: 5] = pr[i][4:0];
        for (int i = 0; i < 64; i++) p1[i*6 +: 6] = pr[i][5:0];
    end

    prio_resolver #(.NBANKS(3), .PRIO_W(5), .SEQ_SCAN(0)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fiq_mode(fiq_mode),
        .pend(pend), .mask(mask), .route(route), .prio(p0),
        .done(done0), .valid(valid0), .index(index0)
    );

    prio_resolver #(.NBANKS(2), .PRIO_W(6), .SEQ_SCAN(1)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .fiq_mode(fiq_mode),
        .pend(pend[63:0]), .mask(mask[63:0]), .route(route[63:0]), .prio(p1),
        .done(done1), .valid(valid1), .index(index1)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_lines();
        pend = '0;
        mask = '1;
        route = '0;
        for (int i = 0; i < 96; i++) pr[i] = 0;
    endtask

    task automatic arm(input int line, input int p, input bit r);
        pend[line] = 1'b1;
        mask[line] = 1'b0;
        route[line] = r;
        pr[line] = p;
    endtask

    // Pulse start; check done just after; wait for u1 and return its latency
    task automatic pulse_start(input string req, output int lat);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(req, "u0 done one cycle after start", int'(done0), 1);
        chk(req, "u1 done low after start", int'(done1), 0);
        lat = 0;
        while (!done1 && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic resolve(input string req);
        int lat;
        pulse_start(req, lat);
        chk("R7", "u1 scan latency", lat, 64);
    endtask

    task automatic t_reset();
        chk("R7", "u0 done at reset", int'(done0), 0);
        chk("R6", "u0 valid at reset", int'(valid0), 0);
        chk("R6", "u0 index at reset", int'(index0), 0);
        chk("R7", "u1 done at reset", int'(done1), 0);
        chk("R6", "u1 valid at reset", int'(valid1), 0);
    endtask

    task automatic t_priority();  // R1
        clear_lines();
        fiq_mode = 1'b0;
        arm(3, 7, 0); arm(10, 2, 0); arm(40, 9, 0); arm(80, 4, 0);
        resolve("R1");
        chk("R1", "u0 smallest priority", int'(index0), 10);
        chk("R1", "u0 valid", int'(valid0), 1);
        chk("R1", "u1 smallest priority", int'(index1), 10);
        clear_lines();
        arm(20, 0, 0); arm(90, 1, 0);
        resolve("R1");
        chk("R1", "u0 zero priority wins", int'(index0), 20);
    endtask

    task automatic t_tie();  // R2, R4
        clear_lines();
        fiq_mode = 1'b0;
        arm(5, 6, 0); arm(37, 6, 0); arm(70, 6, 0); arm(20, 6, 0);
        resolve("R2");
        chk("R2", "u0 tie to highest index", int'(index0), 70);
        chk("R4", "u0 index 2*32+6", int'(index0), 2*32 + 6);
        chk("R2", "u1 tie to highest index", int'(index1), 37);
    endtask

    task automatic t_filter();  // R3
        clear_lines();
        arm(50, 0, 0); mask[50] = 1'b1;
        arm(60, 0, 1); arm(12, 3, 0); arm(2, 5, 1);
        fiq_mode = 1'b0;
        resolve("R3");
        chk("R3", "u0 normal class skips masked and fast", int'(index0), 12);
        chk("R3", "u1 normal class skips masked and fast", int'(index1), 12);
        fiq_mode = 1'b1;
        resolve("R3");
        chk("R3", "u0 fast class", int'(index0), 60);
        chk("R3", "u1 fast class", int'(index1), 60);
    endtask

    task automatic t_none();  // R6 (follows t_filter: index 60 held)
        clear_lines();
        arm(7, 1, 1); arm(44, 1, 1); arm(75, 1, 1);
        fiq_mode = 1'b0;
        resolve("R6");
        chk("R6", "u0 valid with no candidate", int'(valid0), 0);
        chk("R6", "u0 index held", int'(index0), 60);
        chk("R6", "u1 valid with no candidate", int'(valid1), 0);
        chk("R6", "u1 index held", int'(index1), 60);
    endtask

    task automatic t_sticky();  // R7
        repeat (5) @(negedge clk);
        chk("R7", "u0 done stays high", int'(done0), 1);
        chk("R7", "u1 done stays high", int'(done1), 1);
    endtask

    task automatic t_wide();  // R8
        clear_lines();
        fiq_mode = 1'b0;
        arm(1, 32, 0); arm(0, 31, 0); arm(9, 33, 0);
        resolve("R8");
        chk("R8", "u1 six-bit 31 beats 32 and 33", int'(index1), 0);
    endtask

    task automatic t_banks();  // R5
        clear_lines();
        fiq_mode = 1'b0;
        arm(95, 8, 0); arm(64, 8, 0); arm(63, 30, 0);
        resolve("R5");
        chk("R5", "u0 top line reachable", int'(index0), 95);
        chk("R5", "u1 ignores lines beyond its banks", int'(index1), 63);
    endtask

    task automatic t_restart();  // R9
        int lat;
        clear_lines();
        fiq_mode = 1'b0;
        arm(30, 1, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        clear_lines();
        arm(44, 1, 0);
        pulse_start("R9", lat);
        chk("R9", "u1 latency counted from new start", lat, 64);
        chk("R9", "u1 result from new inputs", int'(index1), 44);
        chk("R9", "u1 valid", int'(valid1), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_priority();
        t_tie();
        t_filter();
        t_none();
        t_sticky();
        t_wide();
        t_banks();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule